// File: doc/BRIEF.md
# Timer interrupt entry sequencer

This block steers a simple processor core into a timer interrupt handler and brings it back. It owns the core's machine state word and two save registers. Two timer sources raise requests: an interval timer and a fixed-period timer. Each request is qualified by its own enable and by the external-enable bit of the state word. When a qualified request is seen at a clock edge, the request is taken on that edge. The address of the next sequential instruction goes into the PC save register. The whole state word goes into the state save register. The state word then has a fixed set of control bits cleared. On the following cycle a redirect pulse appears, carrying the handler address. That address is built from a 16-bit prefix and a fixed offset for each source.

A return strobe undoes the entry. It reloads the state word from the state save register and issues a redirect to the saved PC. The core may also load the state word directly through a plain write port. The redirect output is a one-cycle control strobe with no ready signal. The core must accept every redirect in the cycle it appears, so there is no back-pressure on this block. The timer counters, instruction decode and other exception kinds sit outside the block.

Top module: `tmr_irq_seq`

## Requirements
- R1: When a timer request is taken, `sav_pc_o` takes the value of `nia_i` and `sav_st_o` takes the value the state word had before that edge. Both change on the same clock edge.
- R2: On entry the state word has bits 18, 15, 14, 10, 5 and 4 cleared (mask 0x0004C430). Bit 18 is wait-enable, bit 15 is external-enable, bit 14 is problem state, bit 10 is debug wait-enable, bit 5 is instruction relocate and bit 4 is data relocate. Every other bit keeps its value, including bit 17 (critical enable), bit 12 (machine-check enable) and bit 9 (debug enable).
- R3: The handler address is `{pfx_i, 16'h1000}` for an interval timer entry and `{pfx_i, 16'h1010}` for a fixed-period timer entry.
- R4: A source's request is qualified only when its pending input, its enable input and state bit 15 are all 1. A request that is not qualified changes no state and produces no redirect.
- R5: If both sources are qualified on the same edge, only the interval timer is taken. The fixed-period request stays pending and is taken after a return has restored bit 15.
- R6: A return strobe loads the state word from `sav_st_o`. On the next cycle it gives a redirect to the value of `sav_pc_o`, with source code 3. The save registers do not change.
- R7: A return strobe has priority over a qualified request on the same edge. That request is judged again on the next edge against the restored state word.
- R8: A state write (`st_wr_i`) loads `st_wdata_i` into the state word only when neither a return nor an entry happens on that edge. Otherwise the write is dropped.
- R9: `redir_vld_o` is high for exactly one cycle after each entry or return edge. `redir_src_o` is 1 for the interval timer, 2 for the fixed-period timer and 3 for a return. `redir_pc_o` and `redir_src_o` are 0 while `redir_vld_o` is low.
- R10: While `rst_n` is low, the state word, both save registers and all redirect outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nia_i | input | 32 | Next sequential instruction address from the pipeline |
| pfx_i | input | 16 | Handler address prefix (upper half of the vector) |
| ivt_pend_i | input | 1 | Interval timer request pending |
| ivt_en_i | input | 1 | Interval timer interrupt enable |
| fxt_pend_i | input | 1 | Fixed-period timer request pending |
| fxt_en_i | input | 1 | Fixed-period timer interrupt enable |
| ret_i | input | 1 | Return-from-interrupt strobe |
| st_wr_i | input | 1 | Direct state word write strobe |
| st_wdata_i | input | 32 | Data for a direct state word write |
| st_o | output | 32 | Current machine state word |
| sav_pc_o | output | 32 | Saved PC |
| sav_st_o | output | 32 | Saved state word |
| redir_vld_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | 32 | Redirect target address |
| redir_src_o | output | 2 | Redirect cause: 1 interval, 2 fixed-period, 3 return |

## Verification
Three things can land on the same edge: a return strobe, a qualified timer request and a direct state write. Two overlaps are provoked on purpose. A return is issued while a request is pending and enabled, and a state write is issued together with a qualified request. Random traffic with frequent returns and writes adds more overlaps. The bench judges each overlap against a reference model built from the stated priority (return, then entry, then write). The model predicts the exact state word, save registers and redirect for each edge. The bench also checks that a deferred request is taken one edge after the return.

// File: rtl/tmr_irq_seq_pkg.sv
package tmr_irq_seq_pkg;

  // Redirect cause codes seen on redir_src_o
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IVT  = 2'd1,
    SRC_FXT  = 2'd2,
    SRC_RET  = 2'd3
  } redir_src_e;

  // State word bit positions (little-endian index)
  localparam int unsigned ST_WAIT  = 18;
  localparam int unsigned ST_CRIT  = 17;
  localparam int unsigned ST_EXT   = 15;
  localparam int unsigned ST_PROB  = 14;
  localparam int unsigned ST_MCHK  = 12;
  localparam int unsigned ST_DWAIT = 10;
  localparam int unsigned ST_DBG   = 9;
  localparam int unsigned ST_IREL  = 5;
  localparam int unsigned ST_DREL  = 4;

  localparam int unsigned ST_MIN_W = ST_WAIT + 1;

  // Bits cleared when a timer interrupt is entered
  function automatic logic [31:0] entry_clear_mask();
    logic [31:0] m;
    m = '0;
    m[ST_WAIT]  = 1'b1;
    m[ST_EXT]   = 1'b1;
    m[ST_PROB]  = 1'b1;
    m[ST_DWAIT] = 1'b1;
    m[ST_IREL]  = 1'b1;
    m[ST_DREL]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/tis_arb.sv
// Qualifies timer requests and picks one, lowest index first.
module tis_arb #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            ext_en_i,
  input  logic            hold_i,
  output logic [NSRC-1:0] grant_o,
  output logic            take_o
);

  logic [NSRC-1:0] qual;
  logic [NSRC:0]   seen;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_src
      assign qual[gi]    = pend_i[gi] & en_i[gi] & ext_en_i;
      assign seen[gi+1]  = seen[gi] | qual[gi];
      assign grant_o[gi] = qual[gi] & ~seen[gi] & ~hold_i;
    end
  endgenerate

  assign take_o = |grant_o;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));                                                  // R5

  AST_LOW_INDEX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[1] |-> !(pend_i[0] && en_i[0]));                             // R5

  AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (|(grant_o & pend_i & en_i)));                            // R4

endmodule

// File: rtl/tis_vec.sv
// Builds the handler address from the prefix and the granted source offset.
module tis_vec #(
  parameter int unsigned NSRC    = 2,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PFX_W   = 16,
  parameter logic [NSRC*(PC_W-PFX_W)-1:0] OFS_FLAT = {16'h1010, 16'h1000}
) (
  input  logic [PFX_W-1:0] pfx_i,
  input  logic [NSRC-1:0]  grant_i,
  output logic [PC_W-1:0]  vec_o
);

  localparam int unsigned LO_W = PC_W - PFX_W;

  logic [NSRC-1:0][LO_W-1:0] term;
  logic [LO_W-1:0]           lo;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_ofs
      assign term[gi] = grant_i[gi] ? OFS_FLAT[gi*LO_W +: LO_W] : '0;
    end
  endgenerate

  always_comb begin
    lo = '0;
    for (int i = 0; i < NSRC; i++) begin
      lo = lo | term[i];
    end
  end

  assign vec_o = {pfx_i, lo};

endmodule

// File: rtl/tis_save.sv
// Save registers for the interrupted PC and state word.
module tis_save #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned ST_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [PC_W-1:0] nia_i,
  input  logic [ST_W-1:0] st_i,
  output logic [PC_W-1:0] sav_pc_o,
  output logic [ST_W-1:0] sav_st_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sav_pc_o <= '0;
      sav_st_o <= '0;
    end else if (take_i) begin
      sav_pc_o <= nia_i;
      sav_st_o <= st_i;
    end
  end

  AST_SAVE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> sav_pc_o == $past(nia_i));                                // R1

  AST_SAVE_ST: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> sav_st_o == $past(st_i));                                 // R1

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(sav_pc_o) && $stable(sav_st_o));                 // R6

endmodule

// File: rtl/tis_state.sv
// Machine state word: return, then entry, then direct write.
module tis_state
  import tmr_irq_seq_pkg::*;
#(
  parameter int unsigned ST_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_i,
  input  logic            take_i,
  input  logic            wr_i,
  input  logic [ST_W-1:0] wdata_i,
  input  logic [ST_W-1:0] sav_st_i,
  output logic [ST_W-1:0] st_o
);

  localparam logic [31:0]     MASK32 = entry_clear_mask();
  localparam logic [ST_W-1:0] CLR    = ST_W'(MASK32);

  logic [ST_W-1:0] st_d;

  always_comb begin
    st_d = st_o;
    if (ret_i)       st_d = sav_st_i;
    else if (take_i) st_d = st_o & ~CLR;
    else if (wr_i)   st_d = wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_o <= '0;
    else        st_o <= st_d;
  end

  AST_ENTRY_NEEDS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> st_o[ST_EXT]);                                            // R4

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (st_o & CLR) == '0);                                      // R2

  AST_ENTRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (st_o & ~CLR) == ($past(st_o) & ~CLR));                   // R2

  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> st_o == $past(sav_st_i));                                  // R6

  AST_RETURN_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> !take_i);                                                  // R7

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ret_i && !take_i) |=> st_o == $past(wdata_i));             // R8

endmodule

// File: rtl/tmr_irq_seq.sv
module tmr_irq_seq
  import tmr_irq_seq_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PFX_W   = 16,
  parameter int unsigned ST_W    = 32,
  parameter logic [PC_W-PFX_W-1:0] IVT_OFS = 16'h1000,
  parameter logic [PC_W-PFX_W-1:0] FXT_OFS = 16'h1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  nia_i,
  input  logic [PFX_W-1:0] pfx_i,
  input  logic             ivt_pend_i,
  input  logic             ivt_en_i,
  input  logic             fxt_pend_i,
  input  logic             fxt_en_i,
  input  logic             ret_i,
  input  logic             st_wr_i,
  input  logic [ST_W-1:0]  st_wdata_i,
  output logic [ST_W-1:0]  st_o,
  output logic [PC_W-1:0]  sav_pc_o,
  output logic [ST_W-1:0]  sav_st_o,
  output logic             redir_vld_o,
  output logic [PC_W-1:0]  redir_pc_o,
  output logic [1:0]       redir_src_o
);

  localparam int unsigned NSRC = 2;
  localparam int unsigned IDX_IVT = 0;
  localparam int unsigned IDX_FXT = 1;

  logic [NSRC-1:0] pend, en, grant;
  logic            take;
  logic [PC_W-1:0] vec;
  logic [PC_W-1:0] pc_d;
  redir_src_e      src_d;
  logic            vld_d;

  assign pend[IDX_IVT] = ivt_pend_i;
  assign pend[IDX_FXT] = fxt_pend_i;
  assign en[IDX_IVT]   = ivt_en_i;
  assign en[IDX_FXT]   = fxt_en_i;

  tis_arb #(.NSRC(NSRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_i   (pend),
    .en_i     (en),
    .ext_en_i (st_o[ST_EXT]),
    .hold_i   (ret_i),
    .grant_o  (grant),
    .take_o   (take)
  );

  tis_vec #(
    .NSRC     (NSRC),
    .PC_W     (PC_W),
    .PFX_W    (PFX_W),
    .OFS_FLAT ({FXT_OFS, IVT_OFS})
  ) u_vec (
    .pfx_i   (pfx_i),
    .grant_i (grant),
    .vec_o   (vec)
  );

  tis_save #(.PC_W(PC_W), .ST_W(ST_W)) u_save (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .nia_i    (nia_i),
    .st_i     (st_o),
    .sav_pc_o (sav_pc_o),
    .sav_st_o (sav_st_o)
  );

  tis_state #(.ST_W(ST_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .ret_i    (ret_i),
    .take_i   (take),
    .wr_i     (st_wr_i),
    .wdata_i  (st_wdata_i),
    .sav_st_i (sav_st_o),
    .st_o     (st_o)
  );

  // Redirect selection: return wins over any entry on the same edge
  always_comb begin
    vld_d = 1'b0;
    pc_d  = '0;
    src_d = SRC_NONE;
    if (ret_i) begin
      vld_d = 1'b1;
      pc_d  = sav_pc_o;
      src_d = SRC_RET;
    end else if (take) begin
      vld_d = 1'b1;
      pc_d  = vec;
      src_d = grant[IDX_IVT] ? SRC_IVT : SRC_FXT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_vld_o <= 1'b0;
      redir_pc_o  <= '0;
      redir_src_o <= SRC_NONE;
    end else begin
      redir_vld_o <= vld_d;
      redir_pc_o  <= pc_d;
      redir_src_o <= src_d;
    end
  end

  AST_ENTRY_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redir_vld_o && (redir_src_o != SRC_NONE));                  // R9

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> redir_vld_o && redir_pc_o == $past(sav_pc_o));             // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_vld_o |-> (redir_pc_o == '0) && (redir_src_o == SRC_NONE));   // R9

  AST_VECTOR_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ret_i) |=> redir_pc_o[PC_W-1 -: PFX_W] == $past(pfx_i));   // R3

endmodule

// File: tb/sim_tmr_irq_seq.sv
`timescale 1ns/1ps
module sim_tmr_irq_seq;

  localparam logic [31:0] CLR_MASK = 32'h0004_C430;
  localparam int unsigned WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] nia_i = '0;
  logic [15:0] pfx_i = '0;
  logic        ivt_pend_i = 1'b0, ivt_en_i = 1'b0;
  logic        fxt_pend_i = 1'b0, fxt_en_i = 1'b0;
  logic        ret_i = 1'b0, st_wr_i = 1'b0;
  logic [31:0] st_wdata_i = '0;
  logic [31:0] st_o, sav_pc_o, sav_st_o, redir_pc_o;
  logic        redir_vld_o;
  logic [1:0]  redir_src_o;

  always #4 clk = ~clk;  // 125 MHz

  tmr_irq_seq u0 (
    .clk(clk), .rst_n(rst_n), .nia_i(nia_i), .pfx_i(pfx_i),
    .ivt_pend_i(ivt_pend_i), .ivt_en_i(ivt_en_i),
    .fxt_pend_i(fxt_pend_i), .fxt_en_i(fxt_en_i),
    .ret_i(ret_i), .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .st_o(st_o), .sav_pc_o(sav_pc_o), .sav_st_o(sav_st_o),
    .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o),
    .redir_src_o(redir_src_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  // Reference model state
  logic [31:0] m_st = '0, m_s0 = '0, m_s1 = '0, m_pc = '0;
  logic        m_vld = 1'b0;
  logic [1:0]  m_src = '0;
  string       t_st = "R10", t_sv = "R10", t_out = "R10";

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp(t_st,  "state",    st_o,       m_st);
    cmp(t_sv,  "save_pc",  sav_pc_o,   m_s0);
    cmp(t_sv,  "save_st",  sav_st_o,   m_s1);
    cmp(t_out, "redir_vld", {31'd0, redir_vld_o}, {31'd0, m_vld});
    cmp(t_out, "redir_pc", redir_pc_o, m_pc);
    cmp(t_out, "redir_src", {30'd0, redir_src_o}, {30'd0, m_src});
  endtask

  function automatic logic [31:0] entry_state(input logic [31:0] s);
    return s & ~CLR_MASK;
  endfunction

  function automatic logic [31:0] vector(input logic [15:0] p, input bit ivt);
    return {p, ivt ? 16'h1000 : 16'h1010};
  endfunction

  // Drive inputs for the next edge and advance the model
  task automatic apply(input logic [31:0] nia, input logic [15:0] pfx,
                       input logic ip, input logic ie,
                       input logic fp, input logic fe,
                       input logic rt, input logic wr,
                       input logic [31:0] wd);
    logic qi, qf;
    nia_i = nia; pfx_i = pfx;
    ivt_pend_i = ip; ivt_en_i = ie;
    fxt_pend_i = fp; fxt_en_i = fe;
    ret_i = rt; st_wr_i = wr; st_wdata_i = wd;
    qi = ip & ie & m_st[15];
    qf = fp & fe & m_st[15];
    if (rt) begin
      m_vld = 1'b1; m_pc = m_s0; m_src = 2'd3; m_st = m_s1;
      t_st = "R6"; t_sv = "R6"; t_out = (qi | qf) ? "R7" : "R6";
    end else if (qi | qf) begin
      m_s0 = nia; m_s1 = m_st; m_st = entry_state(m_st);
      m_vld = 1'b1; m_pc = vector(pfx, qi); m_src = qi ? 2'd1 : 2'd2;
      t_sv = "R1"; t_st = wr ? "R8" : "R2"; t_out = (qi & qf) ? "R5" : "R3";
    end else begin
      m_vld = 1'b0; m_pc = '0; m_src = '0;
      if (wr) begin m_st = wd; t_st = "R8"; end
      else t_st = "R9";
      t_sv = "R9"; t_out = (ip | fp) ? "R4" : "R9";
    end
  endtask

  task automatic step(input logic [31:0] nia, input logic [15:0] pfx,
                      input logic ip, input logic ie,
                      input logic fp, input logic fe,
                      input logic rt, input logic wr,
                      input logic [31:0] wd);
    apply(nia, pfx, ip, ie, fp, fe, rt, wr, wd);
    @(negedge clk);
    check_all();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4051));
    repeat (3) @(negedge clk);
    t_st = "R10"; t_sv = "R10"; t_out = "R10";
    check_all();
    rst_n = 1'b1;

    // Directed: enable external bit (R8), then both timers together (R5)
    step(32'h0000_0100, 16'hABCD, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step(32'h0000_2004, 16'hABCD, 1, 1, 1, 1, 0, 0, '0);
    // FIT still pending but external bit now clear: ignored (R4)
    step(32'h0000_2008, 16'hABCD, 0, 1, 1, 1, 0, 0, '0);
    // Return with FIT pending on the same edge (R7)
    step(32'h0000_200C, 16'hABCD, 0, 1, 1, 1, 1, 0, '0);
    // Deferred FIT taken now (R3)
    step(32'h0000_3000, 16'h1234, 0, 1, 1, 1, 0, 0, '0);
    // Write on same edge as return: dropped (R8)
    step(32'h0000_3004, 16'h1234, 0, 0, 0, 0, 1, 1, 32'h0);
    // Write on same edge as entry: dropped, entry done (R8, R2)
    step(32'h0000_4000, 16'h5555, 1, 1, 0, 0, 0, 1, 32'h0000_0000);
    step(32'h0000_4004, 16'h5555, 0, 0, 0, 0, 1, 0, '0);
    // Enable low with pending: ignored (R4)
    step(32'h0000_5000, 16'h7777, 1, 0, 1, 0, 0, 0, '0);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] wd;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[15] = 1'b1;
      step($urandom, 16'($urandom),
           1'($urandom), ($urandom % 4) != 0,
           1'($urandom), ($urandom % 4) != 0,
           ($urandom % 8) == 0, ($urandom % 6) == 0, wd);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule